// File: doc/BRIEF.md
# Multi-Mode Palette and Bypass Pixel Color Path

This block turns one pixel per clock into three 8-bit channel codes (red, green, blue) for a triple video DAC. Pixel data enters on three byte-wide groups. A 3-bit mode field picks how those bits are read: as three palette indices, as a packed 15-bit color, as one 8-bit index, or as direct color with zero-filled low bits. Three 256-entry by 8-bit palette RAMs produce the color in the palette modes. A pixel read mask gates the palette index in the two full-byte palette modes only.

A 4-bit overlay input overrides the pixel result in every mode. It selects one of fifteen host-programmed 24-bit colors. A small host write port loads the palettes, the mask and the overlay colors. The mask value is always visible on a read-back output. Every mode has the same fixed two-cycle latency, so the mode may change on any pixel without shifting the pixel stream.

Top module: `ramdac_color_path`

## Requirements
- R1: With `mode`=0 (24-bit palette), the output is `{palR[pix_r&M], palG[pix_g&M], palB[pix_b&M]}`, where M is the read mask.
- R2: With `mode`=1 (24-bit bypass), the output is `{pix_r, pix_g, pix_b}` unchanged. Codes 6 and 7 behave the same way.
- R3: In both 15-bit modes (`mode`=2 and 3), red is `pix_r[6:2]`, green is `{pix_r[1:0],pix_g[7:5]}` and blue is `pix_g[4:0]`. Changing `pix_r[7]` or any bit of `pix_b` does not change the output.
- R4: With `mode`=3 (15-bit bypass), each 5-bit component appears on bits [7:3] of its channel, and bits [2:0] are zero.
- R5: With `mode`=2 (15-bit palette), each channel is its palette read at address `{3'b111, component}`.
- R6: With `mode`=4 (8-bit pseudo-color), the byte picked by `grp_sel` (0=`pix_r`, 1=`pix_g`, 2 or 3=`pix_b`), ANDed with M, indexes all three palettes.
- R7: With `mode`=5 (8-bit bypass), the selected byte S gives red `{S[7:5],5'b0}`, green `{S[4:2],5'b0}` and blue `{S[1:0],6'b0}`.
- R8: The read mask (bit i gates index bit i) is applied in modes 0 and 4 only. It has no effect in modes 2, 3, 5 or 1.
- R9: A write with `host_sel`=3 loads `host_wdata` into three identical mask copies (red, green, blue). `host_mask` shows the mask from the cycle after the write. The mask resets to 8'hFF.
- R10: When `ovl` is nonzero, the output is overlay color entry `ovl` in every mode. When `ovl` is zero, the pixel result passes through.
- R11: Each output reflects the inputs presented exactly two clock cycles earlier in every mode, including when the mode changes on every pixel.
- R12: While reset is active, and until the first pixel reaches the output, all three channel outputs are zero.
- R13: A host write with `host_sel` 0, 1 or 2 writes palette red, green or blue at `host_addr`. A write with `host_sel` 4, 5 or 6 writes the red, green or blue byte of overlay entry `host_addr[3:0]`; writes to entry 0 are discarded. A palette write is used by pixels presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 3 | Color mode for the current pixel |
| grp_sel | input | 2 | Source byte for the 8-bit modes |
| pix_r | input | 8 | Red pixel byte group |
| pix_g | input | 8 | Green pixel byte group |
| pix_b | input | 8 | Blue pixel byte group |
| ovl | input | 4 | Overlay select; zero passes the pixel through |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 3 | Host write target |
| host_addr | input | 8 | Palette address or overlay entry |
| host_wdata | input | 8 | Host write data |
| host_mask | output | 8 | Read-back of the pixel read mask |
| dac_r | output | 8 | Red channel code |
| dac_g | output | 8 | Green channel code |
| dac_b | output | 8 | Blue channel code |

## Verification
A corrupted palette entry or a masked index bit shows up as a wrong channel code exactly two cycles after the pixel that uses it. It stays hidden until such a pixel arrives, so the palettes are loaded with values that differ per entry and per channel. A mask copy that disagrees with the others changes only one channel in modes 0 and 4, so these modes are tested with a partial mask. A pipeline stage that is skipped or added moves every result by one pixel; back-to-back mode changes then show up at once as mismatches.

// File: rtl/rcp_pkg.sv
package rcp_pkg;
  localparam int unsigned CW      = 8;
  localparam int unsigned NCH     = 3;
  localparam int unsigned PIX_W   = NCH * CW;
  localparam int unsigned PAL_DEP = 1 << CW;
  localparam int unsigned SHORT_W = 5;
  localparam int unsigned TOP_W   = CW - SHORT_W;

  localparam logic [2:0] MODE_P24 = 3'd0;
  localparam logic [2:0] MODE_B24 = 3'd1;
  localparam logic [2:0] MODE_P15 = 3'd2;
  localparam logic [2:0] MODE_B15 = 3'd3;
  localparam logic [2:0] MODE_P8  = 3'd4;
  localparam logic [2:0] MODE_B8  = 3'd5;

  localparam logic [2:0] TGT_PAL_R = 3'd0;
  localparam logic [2:0] TGT_PAL_G = 3'd1;
  localparam logic [2:0] TGT_PAL_B = 3'd2;
  localparam logic [2:0] TGT_MASK  = 3'd3;
  localparam logic [2:0] TGT_OVL_R = 3'd4;
  localparam logic [2:0] TGT_OVL_G = 3'd5;
  localparam logic [2:0] TGT_OVL_B = 3'd6;
endpackage

// File: rtl/rcp_reset_sync.sv
module rcp_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rcp_palette.sv
module rcp_palette #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rcp_host_regs.sv
module rcp_host_regs
  import rcp_pkg::*;
#(
  parameter int unsigned OVL_W = 4,
  localparam int unsigned OVL_N = (1 << OVL_W) - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic [2:0]           host_sel,
  input  logic [CW-1:0]        host_addr,
  input  logic [CW-1:0]        host_wdata,
  input  logic [OVL_W-1:0]     ovl_idx,
  output logic [NCH-1:0]       pal_we,
  output logic [NCH-1:0][CW-1:0] mask_cp,
  output logic [PIX_W-1:0]     ovl_color
);
  logic                    mask_we;
  logic [NCH-1:0]          ovl_lane_we;
  logic [OVL_N:0][PIX_W-1:0] ovl_tab;

  always_comb begin
    pal_we      = '0;
    ovl_lane_we = '0;
    mask_we     = 1'b0;
    if (host_wr) begin
      unique case (host_sel)
        TGT_PAL_R: pal_we[2]      = 1'b1;
        TGT_PAL_G: pal_we[1]      = 1'b1;
        TGT_PAL_B: pal_we[0]      = 1'b1;
        TGT_MASK:  mask_we        = 1'b1;
        TGT_OVL_R: ovl_lane_we[2] = 1'b1;
        TGT_OVL_G: ovl_lane_we[1] = 1'b1;
        TGT_OVL_B: ovl_lane_we[0] = 1'b1;
        default:   mask_we        = 1'b0;
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_mask
    logic [CW-1:0] m_d, m_q;
    always_comb begin
      m_d = m_q;
      if (mask_we) m_d = host_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_q <= '1;
      else        m_q <= m_d;
    end
    assign mask_cp[c] = m_q;
  end

  for (genvar e = 0; e <= OVL_N; e++) begin : g_ovl
    if (e == 0) begin : g_none
      assign ovl_tab[e] = '0;
    end else begin : g_ent
      logic           hit;
      logic [PIX_W-1:0] ent_d, ent_q;
      assign hit = (host_addr[OVL_W-1:0] == OVL_W'(e));
      always_comb begin
        ent_d = ent_q;
        for (int l = 0; l < NCH; l++) begin
          if (hit && ovl_lane_we[l]) ent_d[l*CW +: CW] = host_wdata;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
      end
      assign ovl_tab[e] = ent_q;
    end
  end

  assign ovl_color = ovl_tab[ovl_idx];
endmodule

// File: rtl/rcp_index_stage.sv
module rcp_index_stage
  import rcp_pkg::*;
#(
  parameter int unsigned OVL_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             mode,
  input  logic [1:0]             grp_sel,
  input  logic [CW-1:0]          pix_r,
  input  logic [CW-1:0]          pix_g,
  input  logic [CW-1:0]          pix_b,
  input  logic [OVL_W-1:0]       ovl,
  input  logic [NCH-1:0][CW-1:0] mask_cp,
  output logic [NCH-1:0][CW-1:0] addr_q,
  output logic [PIX_W-1:0]       byp_q,
  output logic                   use_pal_q,
  output logic [OVL_W-1:0]       ovl_q
);
  logic [CW-1:0]          sel_byte;
  logic [SHORT_W-1:0]     c5_r, c5_g, c5_b;
  logic [NCH-1:0][CW-1:0] addr_d;
  logic [PIX_W-1:0]       byp_d;
  logic                   use_pal_d;

  always_comb begin
    unique case (grp_sel)
      2'd0:    sel_byte = pix_r;
      2'd1:    sel_byte = pix_g;
      default: sel_byte = pix_b;
    endcase
  end

  assign c5_r = pix_r[CW-2 -: SHORT_W];
  assign c5_g = {pix_r[1:0], pix_g[CW-1 -: TOP_W]};
  assign c5_b = pix_g[SHORT_W-1:0];

  always_comb begin
    addr_d    = '0;
    byp_d     = '0;
    use_pal_d = 1'b0;
    unique case (mode)
      MODE_P24: begin
        use_pal_d = 1'b1;
        addr_d[2] = pix_r & mask_cp[2];
        addr_d[1] = pix_g & mask_cp[1];
        addr_d[0] = pix_b & mask_cp[0];
      end
      MODE_P15: begin
        use_pal_d = 1'b1;
        addr_d[2] = {{TOP_W{1'b1}}, c5_r};
        addr_d[1] = {{TOP_W{1'b1}}, c5_g};
        addr_d[0] = {{TOP_W{1'b1}}, c5_b};
      end
      MODE_B15: byp_d = {c5_r, {TOP_W{1'b0}}, c5_g, {TOP_W{1'b0}},
                         c5_b, {TOP_W{1'b0}}};
      MODE_P8: begin
        use_pal_d = 1'b1;
        for (int c = 0; c < NCH; c++) addr_d[c] = sel_byte & mask_cp[c];
      end
      MODE_B8:  byp_d = {sel_byte[7:5], 5'b0, sel_byte[4:2], 5'b0,
                         sel_byte[1:0], 6'b0};
      default:  byp_d = {pix_r, pix_g, pix_b};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      byp_q     <= '0;
      use_pal_q <= 1'b0;
      ovl_q     <= '0;
    end else begin
      addr_q    <= addr_d;
      byp_q     <= byp_d;
      use_pal_q <= use_pal_d;
      ovl_q     <= ovl;
    end
  end
endmodule

// File: rtl/ramdac_color_path.sv
module ramdac_color_path
  import rcp_pkg::*;
#(
  parameter int unsigned OVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic [1:0]       grp_sel,
  input  logic [7:0]       pix_r,
  input  logic [7:0]       pix_g,
  input  logic [7:0]       pix_b,
  input  logic [OVL_W-1:0] ovl,
  input  logic             host_wr,
  input  logic [2:0]       host_sel,
  input  logic [7:0]       host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_mask,
  output logic [7:0]       dac_r,
  output logic [7:0]       dac_g,
  output logic [7:0]       dac_b
);
  logic                   rst_sync;
  logic [NCH-1:0]         pal_we;
  logic [NCH-1:0][CW-1:0] mask_cp;
  logic [PIX_W-1:0]       ovl_color;
  logic [NCH-1:0][CW-1:0] addr_q;
  logic [NCH-1:0][CW-1:0] pal_rd;
  logic [PIX_W-1:0]       byp_q;
  logic                   use_pal_q;
  logic [OVL_W-1:0]       ovl_q;
  logic [PIX_W-1:0]       out_d, out_q;

  rcp_reset_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync));

  rcp_host_regs #(.OVL_W(OVL_W)) i_regs (
    .clk(clk), .rst_n(rst_sync), .host_wr(host_wr), .host_sel(host_sel),
    .host_addr(host_addr), .host_wdata(host_wdata), .ovl_idx(ovl_q),
    .pal_we(pal_we), .mask_cp(mask_cp), .ovl_color(ovl_color)
  );

  rcp_index_stage #(.OVL_W(OVL_W)) i_idx (
    .clk(clk), .rst_n(rst_sync), .mode(mode), .grp_sel(grp_sel),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .ovl(ovl),
    .mask_cp(mask_cp), .addr_q(addr_q), .byp_q(byp_q),
    .use_pal_q(use_pal_q), .ovl_q(ovl_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_pal
    rcp_palette #(.AW(CW), .DW(CW)) i_pal (
      .clk(clk), .we(pal_we[c]), .waddr(host_addr), .wdata(host_wdata),
      .raddr(addr_q[c]), .rdata(pal_rd[c])
    );
  end

  always_comb begin
    if (ovl_q != '0)    out_d = ovl_color;
    else if (use_pal_q) out_d = pal_rd;
    else                out_d = byp_q;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) out_q <= '0;
    else           out_q <= out_d;
  end

  assign {dac_r, dac_g, dac_b} = out_q;
  assign host_mask = mask_cp[2];
endmodule

// File: rtl/rcp_checker.sv
module rcp_checker #(
  parameter int unsigned OVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode,
  input logic [1:0]       grp_sel,
  input logic [7:0]       pix_r,
  input logic [7:0]       pix_g,
  input logic [7:0]       pix_b,
  input logic [OVL_W-1:0] ovl,
  input logic [2:0][7:0]  mask_cp,
  input logic [7:0]       dac_r,
  input logic [7:0]       dac_g,
  input logic [7:0]       dac_b
);
  logic [1:0] warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R2: straight bypass reproduces the input bytes two cycles later
  assert_byp24_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && $past(ovl, 2) == '0 &&
     ($past(mode, 2) == 3'd1 || $past(mode, 2) >= 3'd6))
    |-> {dac_r, dac_g, dac_b} == $past({pix_r, pix_g, pix_b}, 2));

  // R4: 15-bit bypass leaves the three low bits of every channel clear
  assert_byp15_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && $past(ovl, 2) == '0 && $past(mode, 2) == 3'd3)
    |-> (dac_r[2:0] == 3'd0 && dac_g[2:0] == 3'd0 && dac_b[2:0] == 3'd0));

  // R7: 8-bit bypass fills the low bits with zeros and takes the high bits from the byte
  assert_byp8_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && $past(ovl, 2) == '0 && $past(mode, 2) == 3'd5)
    |-> (dac_r[4:0] == 5'd0 && dac_g[4:0] == 5'd0 && dac_b[5:0] == 6'd0 &&
         dac_b[7:6] == $past(grp_sel == 2'd0 ? pix_r[1:0] :
                             grp_sel == 2'd1 ? pix_g[1:0] : pix_b[1:0], 2)));

  // R9: the three mask copies never disagree
  assert_mask_copies_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_cp[0] == mask_cp[1]) && (mask_cp[1] == mask_cp[2]));
endmodule

bind ramdac_color_path rcp_checker #(.OVL_W(OVL_W)) i_chk (
  .clk(clk), .rst_n(rst_sync), .mode(mode), .grp_sel(grp_sel),
  .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .ovl(ovl),
  .mask_cp(mask_cp), .dac_r(dac_r), .dac_g(dac_g), .dac_b(dac_b)
);

// File: tb/test_ramdac_color_path.sv
module test_ramdac_color_path;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] mode;
  logic [1:0] grp_sel;
  logic [7:0] pix_r, pix_g, pix_b;
  logic [3:0] ovl;
  logic       host_wr;
  logic [2:0] host_sel;
  logic [7:0] host_addr, host_wdata;
  logic [7:0] host_mask, dac_r, dac_g, dac_b;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ramdac_color_path i_ramdac_color_path (
    .clk(clk), .rst_n(rst_n), .mode(mode), .grp_sel(grp_sel),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .ovl(ovl),
    .host_wr(host_wr), .host_sel(host_sel), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_mask(host_mask),
    .dac_r(dac_r), .dac_g(dac_g), .dac_b(dac_b)
  );

  typedef struct {
    bit          chk;
    logic [23:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          n_checks = 0;
  int          n_errors = 0;
  logic [7:0]  m_pal [3][256];
  logic [23:0] m_ovl [16];
  logic [7:0]  m_mask;

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] model(input logic [2:0] m, input logic [1:0] gs,
      input logic [7:0] r, input logic [7:0] g, input logic [7:0] b, input logic [3:0] o);
    logic [7:0] s;
    logic [4:0] cr, cg, cb;
    if (o != 4'd0) return m_ovl[o];
    s  = (gs == 2'd0) ? r : (gs == 2'd1) ? g : b;
    cr = r[6:2];
    cg = {r[1:0], g[7:5]};
    cb = g[4:0];
    case (m)
      3'd0: return {m_pal[0][r & m_mask], m_pal[1][g & m_mask], m_pal[2][b & m_mask]};
      3'd2: return {m_pal[0][{3'b111, cr}], m_pal[1][{3'b111, cg}], m_pal[2][{3'b111, cb}]};
      3'd3: return {cr, 3'b000, cg, 3'b000, cb, 3'b000};
      3'd4: return {m_pal[0][s & m_mask], m_pal[1][s & m_mask], m_pal[2][s & m_mask]};
      3'd5: return {s[7:5], 5'b0, s[4:2], 5'b0, s[1:0], 6'b0};
      default: return {r, g, b};
    endcase
  endfunction

  task automatic put_pixel(input logic [2:0] m, input logic [1:0] gs, input logic [7:0] r,
      input logic [7:0] g, input logic [7:0] b, input logic [3:0] o, input string tag);
    item_t it;
    @(negedge clk);
    host_wr = 1'b0;
    mode = m; grp_sel = gs; pix_r = r; pix_g = g; pix_b = b; ovl = o;
    it.chk = (tag != "");
    it.exp = model(m, gs, r, g, b, o);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic host_write(input logic [2:0] s, input logic [7:0] a, input logic [7:0] d);
    item_t it;
    @(negedge clk);
    host_wr = 1'b1; host_sel = s; host_addr = a; host_wdata = d;
    it.chk = 1'b0; it.exp = '0; it.tag = "";
    sb_q.push_back(it);
    case (s)
      3'd0, 3'd1, 3'd2: m_pal[s][a] = d;
      3'd3: m_mask = d;
      3'd4: if (a[3:0] != 0) m_ovl[a[3:0]][23:16] = d;
      3'd5: if (a[3:0] != 0) m_ovl[a[3:0]][15:8] = d;
      3'd6: if (a[3:0] != 0) m_ovl[a[3:0]][7:0] = d;
      default: ;
    endcase
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD / 4);
      if (sb_q.size() >= 2) begin
        it = sb_q.pop_front();
        if (it.chk) check(it.tag, {dac_r, dac_g, dac_b}, it.exp);
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin : driver
    for (int e = 0; e < 16; e++) m_ovl[e] = '0;
    m_mask = 8'hFF;
    rst_n = 1'b0; mode = '0; grp_sel = '0; pix_r = '0; pix_g = '0; pix_b = '0;
    ovl = '0; host_wr = 1'b0; host_sel = '0; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    check("R12 reset outputs", {dac_r, dac_g, dac_b}, 24'h0);
    check("R9 reset mask", {16'h0, host_mask}, 24'h0000FF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 after release", {dac_r, dac_g, dac_b}, 24'h0);

    // R13: palette load, distinct per entry and channel
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++)
        host_write(3'(c), 8'(i), 8'(i * (2 * c + 3) + c * 41));
    for (int e = 1; e < 16; e++) begin
      host_write(3'd4, 8'(e), 8'(e * 16 + 1));
      host_write(3'd5, 8'(e), 8'(e * 9));
      host_write(3'd6, 8'(e), 8'(255 - e * 7));
    end
    host_write(3'd4, 8'h00, 8'hAA);

    put_pixel(3'd0, 2'd0, 8'h12, 8'h34, 8'h56, 4'd0, "R1 palette 24 a");
    put_pixel(3'd0, 2'd0, 8'hFF, 8'h00, 8'h80, 4'd0, "R1 palette 24 b");
    put_pixel(3'd0, 2'd0, 8'hA5, 8'h5A, 8'h3C, 4'd0, "R1 palette 24 c");

    host_write(3'd3, 8'h00, 8'h0F);
    put_pixel(3'd0, 2'd0, 8'h00, 8'h00, 8'h00, 4'd0, "");
    check("R9 mask readback", {16'h0, host_mask}, 24'h00000F);
    put_pixel(3'd0, 2'd0, 8'hA5, 8'h5A, 8'h3C, 4'd0, "R8 mask in 24 palette");
    put_pixel(3'd4, 2'd0, 8'hC3, 8'h7E, 8'h99, 4'd0, "R6 pseudo grp R");
    put_pixel(3'd4, 2'd1, 8'hC3, 8'h7E, 8'h99, 4'd0, "R6 pseudo grp G");
    put_pixel(3'd4, 2'd2, 8'hC3, 8'h7E, 8'h99, 4'd0, "R6 pseudo grp B");
    put_pixel(3'd4, 2'd3, 8'hC3, 8'h7E, 8'h99, 4'd0, "R6 pseudo grp 3");
    put_pixel(3'd2, 2'd0, 8'hFF, 8'hFF, 8'h00, 4'd0, "R5 palette 15 top");
    put_pixel(3'd2, 2'd0, 8'h7B, 8'h2D, 8'hEE, 4'd0, "R8 no mask in 15 palette");
    put_pixel(3'd2, 2'd0, 8'hFB, 8'h2D, 8'h11, 4'd0, "R3 R7 bit and B ignored");
    put_pixel(3'd3, 2'd0, 8'h7B, 8'h2D, 8'hEE, 4'd0, "R4 bypass 15 a");
    put_pixel(3'd3, 2'd0, 8'hFF, 8'hFF, 8'hFF, 4'd0, "R4 bypass 15 ones");
    put_pixel(3'd3, 2'd0, 8'h7F, 8'hFF, 8'h00, 4'd0, "R3 bypass 15 R7 and B");
    put_pixel(3'd1, 2'd0, 8'hDE, 8'hAD, 8'hBE, 4'd0, "R2 bypass 24");
    put_pixel(3'd6, 2'd0, 8'h01, 8'h80, 8'hFE, 4'd0, "R2 code 6");
    put_pixel(3'd7, 2'd0, 8'h55, 8'hAA, 8'h0F, 4'd0, "R2 code 7");
    put_pixel(3'd5, 2'd1, 8'h00, 8'hB6, 8'h00, 4'd0, "R7 bypass 8 grp G");
    put_pixel(3'd5, 2'd0, 8'hFF, 8'h00, 8'h00, 4'd0, "R7 bypass 8 grp R");
    put_pixel(3'd5, 2'd2, 8'h00, 8'h00, 8'h6D, 4'd0, "R8 no mask in 8 bypass");

    host_write(3'd3, 8'h00, 8'hFF);
    for (int o = 1; o < 16; o++)
      put_pixel(3'(o % 6), 2'd0, 8'h3C, 8'hC3, 8'h5A, 4'(o), "R10 overlay override");
    put_pixel(3'd1, 2'd0, 8'h3C, 8'hC3, 8'h5A, 4'd0, "R10 overlay zero passes");

    for (int k = 0; k < 12; k++)
      put_pixel(3'(k % 6), 2'(k % 3), 8'(k * 37), 8'(k * 53 + 7), 8'(255 - k * 19),
                4'd0, "R11 mode change per pixel");

    host_write(3'd0, 8'h40, 8'hEE);
    put_pixel(3'd0, 2'd0, 8'h40, 8'h41, 8'h42, 4'd0, "R13 palette write next cycle");

    repeat (3) put_pixel(3'd0, 2'd0, 8'h00, 8'h00, 8'h00, 4'd0, "");
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule